// File: doc/BRIEF.md
# Runtime-Partitioned SIMD Minimum Unit

This combinational block returns the lesser of two 16-bit operands. A 3-bit partition mask divides the word into SIMD elements while the block runs. The word is built from four 4-bit base lanes. Each mask bit sits on one of the three internal lane boundaries and says whether that boundary splits the word. So one datapath covers all eight layouts, from a single 16-bit element to four 4-bit elements, including mixed layouts such as one 8-bit element beside two 4-bit ones.

Every lane first compares its own slices of the two operands. Inside a joined element, the per-lane less-than and equal flags cascade from the most significant lane downward, so the lane that decides is the highest lane where the operands differ. The decision is then copied to every lane of the element, and each lane takes its data from whichever operand that decision names. The output has no registers. It follows the inputs within the same cycle.

Top module: `simd_min_part`

## Requirements
- R1: Bit k of `split_i` (k = 0..2) is the boundary between lane k (bits 4k..4k+3) and lane k+1. A value of 1 splits the word there, and 0 joins the two lanes into one element. Every one of the 8 mask values is legal.
- R2: With `split_i` = 3'b111, each 4-bit lane of `min_o` is the unsigned minimum of the matching lanes of `x_i` and `y_i`.
- R3: With `split_i` = 3'b000, `min_o` is the unsigned minimum of the full 16-bit operands.
- R4: The compare is unsigned. An element whose top bit is 1 is larger than any element whose top bit is 0.
- R5: Inside a joined element, the most significant lane where `x_i` and `y_i` differ decides the result. Lower lanes cannot override it.
- R6: Every lane of an element takes its output from the same operand. Each output lane equals the matching lane of `x_i` or of `y_i`.
- R7: When the two operands are equal within an element, that element's output is the `y_i` slice.
- R8: The output is combinational. It follows a change of any input in the same cycle, with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 16 | First operand; chosen when strictly less within its element |
| y_i | input | 16 | Second operand; chosen otherwise |
| split_i | input | 3 | Boundary mask; bit k = 1 splits lane k from lane k+1 |
| min_o | output | 16 | Per-element unsigned minimum |

## Verification
The bound checker checks four things on every input change: each output lane comes from one of the two operands, joined neighbouring lanes never mix sources, equal operands give the `y_i` value, and in the all-split and fully-joined layouts the result is no larger than either input. Some behaviours only the bench scenarios can show. These are the exact per-element value for each of the eight mixed layouts, cases where a borrow-like decision in an upper lane must win over a lower lane, unsigned ordering at the top bit, and the output following the inputs with no clock edge. The bench covers them with a behavioural reference model that walks the elements, and it applies that model to every mask value.

// File: rtl/simd_min_pkg.sv
package simd_min_pkg;

    localparam int unsigned LANE_W_DEF = 4;
    localparam int unsigned LANES_DEF  = 4;

    // Result of comparing one lane of x against the same lane of y
    typedef struct packed {
        logic lt;   // x lane strictly below y lane
        logic eq;   // lanes identical
    } lane_flags_t;

    function automatic lane_flags_t compare_lane(input logic [LANE_W_DEF-1:0] a,
                                                 input logic [LANE_W_DEF-1:0] b);
        lane_flags_t f;
        f.lt = (a < b);
        f.eq = (a == b);
        return f;
    endfunction

endpackage

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp
    import simd_min_pkg::*;
#(
    parameter int unsigned LANE_W = LANE_W_DEF,
    parameter int unsigned LANES  = LANES_DEF,
    localparam int unsigned WORD_W = LANE_W * LANES
) (
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    output logic [LANES-1:0]  lt_o,
    output logic [LANES-1:0]  eq_o
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] a_s, b_s;
        assign a_s     = a_i[l*LANE_W +: LANE_W];
        assign b_s     = b_i[l*LANE_W +: LANE_W];
        assign lt_o[l] = (a_s < b_s);
        assign eq_o[l] = (a_s == b_s);
    end
endmodule

// File: rtl/simd_part_chain.sv
module simd_part_chain #(
    parameter int unsigned LANES = 4,
    localparam int unsigned BND_W = LANES - 1
) (
    input  logic [LANES-1:0] lt_i,
    input  logic [LANES-1:0] eq_i,
    input  logic [BND_W-1:0] split_i,
    output logic [LANES-1:0] take_x_o
);
    // edge[j] = 1 when lane j starts a new element (lane 0 and LANES always)
    logic [LANES:0]   edge_v;
    logic [LANES-1:0] lt_acc, eq_acc;

    always_comb begin
        edge_v           = '0;
        edge_v[0]        = 1'b1;
        edge_v[LANES]    = 1'b1;
        edge_v[BND_W:1]  = split_i;
    end

    // Downward cascade: each lane folds in the verdict from the lanes above it
    always_comb begin
        lt_acc = '0;
        eq_acc = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (edge_v[i+1]) begin
                lt_acc[i] = lt_i[i];
                eq_acc[i] = eq_i[i];
            end else begin
                lt_acc[i] = lt_acc[i+1] | (eq_acc[i+1] & lt_i[i]);
                eq_acc[i] = eq_acc[i+1] & eq_i[i];
            end
        end
    end

    // Upward broadcast: the lowest lane of each element holds its verdict
    always_comb begin
        take_x_o = '0;
        for (int i = 0; i < LANES; i++) begin
            if (edge_v[i]) take_x_o[i] = lt_acc[i];
            else           take_x_o[i] = take_x_o[i-1];
        end
    end
endmodule

// File: rtl/simd_lane_mux.sv
module simd_lane_mux #(
    parameter int unsigned LANE_W = 4,
    parameter int unsigned LANES  = 4,
    localparam int unsigned WORD_W = LANE_W * LANES
) (
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic [LANES-1:0]  pick_a_i,
    output logic [WORD_W-1:0] q_o
);
    for (genvar l = 0; l < LANES; l++) begin : g_sel
        assign q_o[l*LANE_W +: LANE_W] = pick_a_i[l] ? a_i[l*LANE_W +: LANE_W]
                                                     : b_i[l*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/simd_min_part.sv
module simd_min_part
    import simd_min_pkg::*;
#(
    parameter int unsigned LANE_W = LANE_W_DEF,
    parameter int unsigned LANES  = LANES_DEF,
    localparam int unsigned WORD_W = LANE_W * LANES,
    localparam int unsigned BND_W  = LANES - 1
) (
    input  logic [WORD_W-1:0] x_i,
    input  logic [WORD_W-1:0] y_i,
    input  logic [BND_W-1:0]  split_i,
    output logic [WORD_W-1:0] min_o
);
    logic [LANES-1:0] lane_lt, lane_eq, take_x;

    simd_lane_cmp #(.LANE_W(LANE_W), .LANES(LANES)) cmp_i (
        .a_i (x_i), .b_i (y_i), .lt_o (lane_lt), .eq_o (lane_eq)
    );

    simd_part_chain #(.LANES(LANES)) chain_i (
        .lt_i (lane_lt), .eq_i (lane_eq), .split_i (split_i), .take_x_o (take_x)
    );

    simd_lane_mux #(.LANE_W(LANE_W), .LANES(LANES)) mux_i (
        .a_i (x_i), .b_i (y_i), .pick_a_i (take_x), .q_o (min_o)
    );
endmodule

// File: rtl/simd_min_part_chk.sv
module simd_min_part_chk #(
    parameter int unsigned LANE_W = 4,
    parameter int unsigned LANES  = 4,
    localparam int unsigned WORD_W = LANE_W * LANES,
    localparam int unsigned BND_W  = LANES - 1
) (
    input logic [WORD_W-1:0] x_i,
    input logic [WORD_W-1:0] y_i,
    input logic [BND_W-1:0]  split_i,
    input logic [WORD_W-1:0] min_o
);
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            // R6: each output lane is copied from one operand
            p_lane_src_r6: assert (min_o[l*LANE_W +: LANE_W] == x_i[l*LANE_W +: LANE_W] ||
                                   min_o[l*LANE_W +: LANE_W] == y_i[l*LANE_W +: LANE_W]);
            // R2: all-split layout gives per-lane minimum bounds
            if (&split_i) begin
                p_lane_bound_r2: assert (min_o[l*LANE_W +: LANE_W] <= x_i[l*LANE_W +: LANE_W] &&
                                         min_o[l*LANE_W +: LANE_W] <= y_i[l*LANE_W +: LANE_W]);
            end
        end
        // R6: joined neighbours with differing operands share one source
        for (int k = 0; k < BND_W; k++) begin
            if (!split_i[k] &&
                x_i[k*LANE_W +: LANE_W]     != y_i[k*LANE_W +: LANE_W] &&
                x_i[(k+1)*LANE_W +: LANE_W] != y_i[(k+1)*LANE_W +: LANE_W]) begin
                p_joined_same_r6: assert ((min_o[k*LANE_W +: LANE_W] == x_i[k*LANE_W +: LANE_W]) ==
                                          (min_o[(k+1)*LANE_W +: LANE_W] == x_i[(k+1)*LANE_W +: LANE_W]));
            end
        end
        // R7: equal operands yield the y value
        if (x_i == y_i) begin
            p_equal_y_r7: assert (min_o == y_i);
        end
        // R3: fully joined layout never exceeds either operand
        if (split_i == '0) begin
            p_full_bound_r3: assert (min_o <= x_i && min_o <= y_i);
        end
    end
endmodule

bind simd_min_part simd_min_part_chk #(.LANE_W(LANE_W), .LANES(LANES)) chk_i (
    .x_i (x_i), .y_i (y_i), .split_i (split_i), .min_o (min_o)
);

// File: tb/simd_min_part_tb_top.sv
module simd_min_part_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 4;
    localparam int NL = 4;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [15:0] x = '0, y = '0;
    logic [2:0]  sp = '0;
    logic [15:0] mo;
    int n_vec = 0, n_bad = 0, cyc = 0;
    bit  done = 0;

    simd_min_part dut_i (.x_i(x), .y_i(y), .split_i(sp), .min_o(mo));

    // Behavioural model: walk elements, compare integers
    function automatic logic [15:0] ref_min(input logic [15:0] a, input logic [15:0] b,
                                            input logic [2:0] m);
        logic [15:0] r = '0;
        int lo = 0;
        for (int l = 0; l < NL; l++) begin
            if (l == NL-1 || m[l]) begin
                int w = (l - lo + 1) * LW;
                int av = (int'(a) >> (lo*LW)) & ((1 << w) - 1);
                int bv = (int'(b) >> (lo*LW)) & ((1 << w) - 1);
                int pv = (av < bv) ? av : bv;
                for (int k = 0; k < w; k++) r[lo*LW + k] = pv[k];
                lo = l + 1;
            end
        end
        return r;
    endfunction

    task automatic check(input string req);
        logic [15:0] e = ref_min(x, y, sp);
        n_vec++;
        if (mo !== e) begin
            n_bad++;
            $display("FAIL %s: x=%h y=%h split=%b got=%h exp=%h", req, x, y, sp, mo, e);
        end
    endtask

    task automatic apply(input logic [15:0] a, input logic [15:0] b,
                         input logic [2:0] m, input string req);
        @(posedge clk);
        x = a; y = b; sp = m;
        @(negedge clk);
        check(req);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: got=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // reset-like idle state: zero inputs give zero output
        apply(16'h0000, 16'h0000, 3'b000, "R7 idle");
        // R3: full-width unsigned minimum
        apply(16'h1234, 16'h1233, 3'b000, "R3");
        apply(16'h0FFF, 16'h1000, 3'b000, "R3");
        // R2: independent 4-bit lanes
        apply(16'h19A2, 16'h91A3, 3'b111, "R2");
        // R4: unsigned top bit
        apply(16'h8000, 16'h7FFF, 3'b000, "R4");
        apply(16'h8F8F, 16'h7070, 3'b101, "R4");
        // R5: upper lane decides despite lower lanes
        apply(16'h10FF, 16'h2000, 3'b000, "R5");
        apply(16'h3F00, 16'h30FF, 3'b011, "R5");
        apply(16'h0F21, 16'h0F1F, 3'b101, "R5");
        // R6: mixed layouts, sources must not mix in an element
        apply(16'hA5C3, 16'hA6B4, 3'b010, "R6");
        apply(16'h5A5A, 16'h5A5B, 3'b100, "R6");
        // R7: equal operands
        apply(16'hBEEF, 16'hBEEF, 3'b001, "R7");
        apply(16'h1234, 16'h1234, 3'b110, "R7");
        // R8: output follows inputs without any clock edge
        @(negedge clk);
        x = 16'h0001; y = 16'h0002; sp = 3'b000;
        #1 check("R8");
        y = 16'h0000;
        #1 check("R8");
        // R1: sweep every mask value with pseudo-random operands
        for (int m = 0; m < 8; m++) begin
            for (int i = 0; i < 300; i++) begin
                logic [15:0] a = 16'($urandom);
                logic [15:0] b = (i % 5 == 0) ? (a ^ (16'h1 << (i % 16))) : 16'($urandom);
                apply(a, b, 3'(m), (m == 7) ? "R2" : (m == 0) ? "R3" : "R1");
            end
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule